// File: doc/BRIEF.md
# Fetch Branch Predictor with History Fallback

This block sits beside the fetch stage and, for every fetch address it is shown, names the address to fetch next. Three structures share the work. A two-way set-associative target buffer remembers where taken branches went. A table of 2-bit saturating counters, indexed by the fetch line XORed with a global history of resolved conditional outcomes, gives the direction; it is the only source of a direction when the target buffer misses. A small return stack supplies the target of return instructions. When nothing predicts a taken branch, the next fetch address is the current one plus the fetch width in bytes.

The lookup is combinational from the fetch address and the stored state. Resolved branches come back through an update port carrying the branch address, its outcome, its target, its kind and whether it was mispredicted. A mispredicted resolution raises a flush request one cycle later; the flush input empties the return stack, since any pushes that had reached it are no longer trusted. The instruction cache and the pipeline flush itself live elsewhere.

Top module: `fetchPredictor`

## Requirements
- R1: After reset every buffer way is invalid, every counter holds 01, the history is zero and the return stack is empty, so every lookup gives predTaken=0, btbHit=0 and predTarget=fetchPc+FETCH_BYTES.
- R2: Whenever predTaken=0, predTarget equals fetchPc+FETCH_BYTES.
- R3: On a target buffer miss, btbHit=0 and predTaken equals bit 1 of the counter at index (fetchPc[OFF+H-1:OFF] XOR history), where OFF=log2(FETCH_BYTES) and H=log2(GHT_ENTRIES); predTarget stays sequential.
- R4: Each resolved conditional branch (kind 0) moves its counter, indexed with the history before the update, one step toward its outcome, saturating at 00 and 11; values 10 and 11 mean taken.
- R5: Each resolved conditional branch shifts its outcome into bit 0 of the H-bit history; other kinds leave the history unchanged.
- R6: A resolved taken branch writes tag, target and kind into the buffer (refreshing the way that already holds it); a not-taken one allocates nothing.
- R7: The set is selected by fetchPc[OFF+S-1:OFF] with S=log2(BTB_ENTRIES/2); a new entry goes to way 0 if invalid, else way 1 if invalid, else the way named by the set's LRU bit; every write makes the other way the LRU way.
- R8: Kind encoding is 0 conditional, 1 jump, 2 call, 3 return. On a hit: jump and call predict taken to the stored target; conditional takes its direction from the counter and, if taken, the stored target; return predicts taken to the top of the return stack, or not taken if the stack is empty.
- R9: A resolved call pushes updPc+FETCH_BYTES; a resolved return pops; a push onto a full stack overwrites the oldest entry; a pop of an empty stack does nothing.
- R10: The flush input empties the return stack and cancels any push or pop in the same cycle.
- R11: flushReq is high in the cycle after an update with updMispredict=1 and low after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the return stack |
| fetchPc | input | PC_W | Address being fetched |
| updValid | input | 1 | A resolved branch is presented |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome |
| updTarget | input | PC_W | Resolved target |
| updKind | input | 2 | 0 cond, 1 jump, 2 call, 3 return |
| updMispredict | input | 1 | The resolved branch was mispredicted |
| predTaken | output | 1 | A taken branch is predicted |
| predTarget | output | PC_W | Next fetch address |
| btbHit | output | 1 | The target buffer holds the fetch line |
| flushReq | output | 1 | Pipeline flush request |

## Verification
The bench builds the predictor with a 16-entry target buffer, 64 counters and a 4-deep return stack. Eight sets with three competing tags force evictions and LRU decisions within a few hundred updates, a 6-bit history makes counter aliasing between lines frequent, and four stack slots let a short run of calls wrap the stack and a short run of returns underflow it.

// File: rtl/bpPkg.sv
package bpPkg;
  typedef enum logic [1:0] {
    KIND_COND = 2'd0,
    KIND_JUMP = 2'd1,
    KIND_CALL = 2'd2,
    KIND_RET  = 2'd3
  } brKind_t;

  typedef struct packed {
    logic btbWe;
    logic btbWay;
    logic ghtWe;
    logic ghtUp;
    logic ghrShift;
    logic rasPush;
    logic rasPop;
    logic rasClear;
  } bpCtrl_t;
endpackage

// File: rtl/bpDatapath.sv
module bpDatapath import bpPkg::*; #(
  parameter int PC_W        = 32,
  parameter int BTB_ENTRIES = 512,
  parameter int GHT_ENTRIES = 4096,
  parameter int RAS_DEPTH   = 8,
  parameter int FETCH_BYTES = 8,
  localparam int OFF_W  = $clog2(FETCH_BYTES),
  localparam int LINE_W = PC_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpCtrl_t           ctrl,
  input  logic [LINE_W-1:0] lkLine,
  input  logic [PC_W-1:0]   updPc,
  input  logic [PC_W-1:0]   updTarget,
  input  logic [1:0]        updKind,
  input  logic              updTaken,
  output logic [1:0]        lkHit,
  output logic [PC_W-1:0]   lkTarget,
  output logic [1:0]        lkKind,
  output logic              lkDirTaken,
  output logic [1:0]        upHit,
  output logic [1:0]        upVld,
  output logic              upLru,
  output logic [1:0]        upCtr,
  output logic [PC_W-1:0]   rasTop,
  output logic              rasValid
);
  localparam int SETS   = BTB_ENTRIES / 2;
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = LINE_W - SET_W;
  localparam int HIST_W = $clog2(GHT_ENTRIES);
  localparam int RAS_W  = $clog2(RAS_DEPTH);
  localparam logic [PC_W-1:0] STEP     = PC_W'(FETCH_BYTES);
  localparam logic [RAS_W:0]  RAS_FULL = (RAS_W+1)'(RAS_DEPTH);

  logic [LINE_W-1:0] upLine;
  logic [SET_W-1:0]  lkSet, upSet;
  logic [TAG_W-1:0]  lkTag, upTag;
  assign upLine = updPc[PC_W-1:OFF_W];
  assign lkSet  = lkLine[SET_W-1:0];
  assign upSet  = upLine[SET_W-1:0];
  assign lkTag  = lkLine[LINE_W-1:SET_W];
  assign upTag  = upLine[LINE_W-1:SET_W];

  // ---------------- target buffer, one generate arm per way
  logic [PC_W-1:0] wayTgt  [2];
  logic [1:0]      wayKind [2];

  for (genvar w = 0; w < 2; w++) begin : gWay
    localparam bit WAY_ID = (w == 1);
    logic [TAG_W-1:0] tagQ  [SETS];
    logic [PC_W-1:0]  tgtQ  [SETS];
    logic [1:0]       kindQ [SETS];
    logic [SETS-1:0]  vldQ;
    logic             wayWe;
    assign wayWe = ctrl.btbWe && (ctrl.btbWay == WAY_ID);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      vldQ <= '0;
      else if (wayWe) vldQ[upSet] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wayWe) begin
        tagQ[upSet]  <= upTag;
        tgtQ[upSet]  <= updTarget;
        kindQ[upSet] <= updKind;
      end
    end

    assign lkHit[w]   = vldQ[lkSet] && (tagQ[lkSet] == lkTag);
    assign upHit[w]   = vldQ[upSet] && (tagQ[upSet] == upTag);
    assign upVld[w]   = vldQ[upSet];
    assign wayTgt[w]  = tgtQ[lkSet];
    assign wayKind[w] = kindQ[lkSet];
  end

  assign lkTarget = lkHit[1] ? wayTgt[1]  : wayTgt[0];
  assign lkKind   = lkHit[1] ? wayKind[1] : wayKind[0];

  logic [SETS-1:0] lruQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lruQ <= '0;
    else if (ctrl.btbWe) lruQ[upSet] <= ~ctrl.btbWay;
  end
  assign upLru = lruQ[upSet];

  // ---------------- global history and counter table
  logic [1:0]        ghtQ [GHT_ENTRIES];
  logic [HIST_W-1:0] ghrQ, lkIdx, upIdx;
  assign lkIdx = lkLine[HIST_W-1:0] ^ ghrQ;
  assign upIdx = upLine[HIST_W-1:0] ^ ghrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < GHT_ENTRIES; i++) ghtQ[i] <= 2'b01;
      ghrQ <= '0;
    end else begin
      if (ctrl.ghtWe)
        ghtQ[upIdx] <= ctrl.ghtUp ? ghtQ[upIdx] + 2'd1 : ghtQ[upIdx] - 2'd1;
      if (ctrl.ghrShift)
        ghrQ <= {ghrQ[HIST_W-2:0], updTaken};
    end
  end
  assign lkDirTaken = ghtQ[lkIdx][1];
  assign upCtr      = ghtQ[upIdx];

  // ---------------- return stack
  logic [PC_W-1:0]  rasQ [RAS_DEPTH];
  logic [RAS_W-1:0] rasPtr;
  logic [RAS_W:0]   rasCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasPtr <= '0;
      rasCnt <= '0;
    end else if (ctrl.rasClear) begin
      rasCnt <= '0;
    end else if (ctrl.rasPush) begin
      rasPtr <= rasPtr + 1'b1;
      if (rasCnt != RAS_FULL) rasCnt <= rasCnt + 1'b1;
    end else if (ctrl.rasPop) begin
      rasPtr <= rasPtr - 1'b1;
      rasCnt <= rasCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.rasPush && !ctrl.rasClear) rasQ[rasPtr] <= updPc + STEP;
  end

  assign rasTop   = rasQ[rasPtr - 1'b1];
  assign rasValid = (rasCnt != '0);

  // ---------------- assertions
  assert_ras_bounded_R9: assert property (@(posedge clk) disable iff (!rstN)
    rasCnt <= RAS_FULL);
  assert_ras_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rasClear |=> (rasCnt == '0));
  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rasPop |-> rasValid);
  assert_single_way_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkHit) && $onehot0(upHit));
  assert_lru_flip_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.btbWe |=> (lruQ[$past(upSet)] != $past(ctrl.btbWay)));
  assert_ctr_top_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.ghtWe && ctrl.ghtUp) |-> (ghtQ[upIdx] != 2'd3));
  assert_ctr_bottom_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.ghtWe && !ctrl.ghtUp) |-> (ghtQ[upIdx] != 2'd0));
endmodule

// File: rtl/bpControl.sv
module bpControl import bpPkg::*; #(
  parameter int PC_W        = 32,
  parameter int FETCH_BYTES = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flush,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            updValid,
  input  logic            updTaken,
  input  logic [1:0]      updKind,
  input  logic            updMispredict,
  input  logic [1:0]      lkHit,
  input  logic [PC_W-1:0] lkTarget,
  input  logic [1:0]      lkKind,
  input  logic            lkDirTaken,
  input  logic [1:0]      upHit,
  input  logic [1:0]      upVld,
  input  logic            upLru,
  input  logic [1:0]      upCtr,
  input  logic [PC_W-1:0] rasTop,
  input  logic            rasValid,
  output bpCtrl_t         ctrl,
  output logic            predTaken,
  output logic [PC_W-1:0] predTarget,
  output logic            btbHit,
  output logic            flushReq
);
  localparam logic [PC_W-1:0] STEP = PC_W'(FETCH_BYTES);

  logic [PC_W-1:0] seqPc;
  brKind_t         hitKind, upKind;
  assign seqPc   = fetchPc + STEP;
  assign btbHit  = |lkHit;
  assign hitKind = brKind_t'(lkKind);
  assign upKind  = brKind_t'(updKind);

  // lookup side: choose direction and target
  always_comb begin
    predTaken  = lkDirTaken;
    predTarget = seqPc;
    if (btbHit) begin
      unique case (hitKind)
        KIND_COND: begin
          predTaken  = lkDirTaken;
          predTarget = lkDirTaken ? lkTarget : seqPc;
        end
        KIND_JUMP, KIND_CALL: begin
          predTaken  = 1'b1;
          predTarget = lkTarget;
        end
        KIND_RET: begin
          predTaken  = rasValid;
          predTarget = rasValid ? rasTop : seqPc;
        end
        default: ;
      endcase
    end
  end

  // update side: strobes towards the datapath
  logic isCond, victimWay, ctrSat;
  assign isCond    = updValid && (upKind == KIND_COND);
  assign victimWay = !upVld[0] ? 1'b0 : (!upVld[1] ? 1'b1 : upLru);
  assign ctrSat    = updTaken ? (upCtr == 2'd3) : (upCtr == 2'd0);

  always_comb begin
    ctrl          = '0;
    ctrl.btbWe    = updValid && updTaken;
    ctrl.btbWay   = (|upHit) ? upHit[1] : victimWay;
    ctrl.ghtWe    = isCond && !ctrSat;
    ctrl.ghtUp    = updTaken;
    ctrl.ghrShift = isCond;
    ctrl.rasClear = flush;
    ctrl.rasPush  = updValid && (upKind == KIND_CALL) && !flush;
    ctrl.rasPop   = updValid && (upKind == KIND_RET) && rasValid && !flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flushReq <= 1'b0;
    else       flushReq <= updValid && updMispredict;
  end

  assert_flush_raise_R11: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updMispredict) |=> flushReq);
  assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(updValid && updMispredict) |=> !flushReq);
  assert_push_pop_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.rasPush && ctrl.rasPop));
endmodule

// File: rtl/fetchPredictor.sv
module fetchPredictor import bpPkg::*; #(
  parameter int PC_W        = 32,
  parameter int BTB_ENTRIES = 512,
  parameter int GHT_ENTRIES = 4096,
  parameter int RAS_DEPTH   = 8,
  parameter int FETCH_BYTES = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flush,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic [PC_W-1:0] updTarget,
  input  logic [1:0]      updKind,
  input  logic            updMispredict,
  output logic            predTaken,
  output logic [PC_W-1:0] predTarget,
  output logic            btbHit,
  output logic            flushReq
);
  localparam int OFF_W = $clog2(FETCH_BYTES);

  bpCtrl_t         ctrl;
  logic [1:0]      lkHit, lkKind, upHit, upVld, upCtr;
  logic [PC_W-1:0] lkTarget, rasTop;
  logic            lkDirTaken, upLru, rasValid;

  bpDatapath #(
    .PC_W(PC_W), .BTB_ENTRIES(BTB_ENTRIES), .GHT_ENTRIES(GHT_ENTRIES),
    .RAS_DEPTH(RAS_DEPTH), .FETCH_BYTES(FETCH_BYTES)
  ) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .lkLine(fetchPc[PC_W-1:OFF_W]),
    .updPc(updPc), .updTarget(updTarget), .updKind(updKind), .updTaken(updTaken),
    .lkHit(lkHit), .lkTarget(lkTarget), .lkKind(lkKind), .lkDirTaken(lkDirTaken),
    .upHit(upHit), .upVld(upVld), .upLru(upLru), .upCtr(upCtr),
    .rasTop(rasTop), .rasValid(rasValid)
  );

  bpControl #(.PC_W(PC_W), .FETCH_BYTES(FETCH_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .fetchPc(fetchPc),
    .updValid(updValid), .updTaken(updTaken), .updKind(updKind),
    .updMispredict(updMispredict),
    .lkHit(lkHit), .lkTarget(lkTarget), .lkKind(lkKind), .lkDirTaken(lkDirTaken),
    .upHit(upHit), .upVld(upVld), .upLru(upLru), .upCtr(upCtr),
    .rasTop(rasTop), .rasValid(rasValid),
    .ctrl(ctrl), .predTaken(predTaken), .predTarget(predTarget),
    .btbHit(btbHit), .flushReq(flushReq)
  );
endmodule

// File: tb/tb_fetchPredictor.sv
`timescale 1ns/1ps
module tb_fetchPredictor;
  localparam int PC_W = 32;
  localparam int NSETS = 8;
  localparam int NCTR = 64;
  localparam int NRAS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic [31:0] fetchPc = '0;
  logic updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic updTaken = 1'b0;
  logic [31:0] updTarget = '0;
  logic [1:0] updKind = '0;
  logic updMispredict = 1'b0;
  logic predTaken, btbHit, flushReq;
  logic [31:0] predTarget;

  always #2 clk = ~clk;

  fetchPredictor #(.PC_W(PC_W), .BTB_ENTRIES(16), .GHT_ENTRIES(NCTR),
                   .RAS_DEPTH(NRAS), .FETCH_BYTES(8)) dut (
    .clk(clk), .rstN(rstN), .flush(flush), .fetchPc(fetchPc),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updTarget(updTarget), .updKind(updKind), .updMispredict(updMispredict),
    .predTaken(predTaken), .predTarget(predTarget), .btbHit(btbHit),
    .flushReq(flushReq)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  bit          mV    [2][NSETS];
  logic [25:0] mTag  [2][NSETS];
  logic [31:0] mTgt  [2][NSETS];
  logic [1:0]  mKind [2][NSETS];
  bit          mLru  [NSETS];
  logic [1:0]  mGht  [NCTR];
  logic [5:0]  mGhr;
  logic [31:0] mRas  [NRAS];
  int mPtr, mCnt;
  bit eTaken, eHit;
  logic [31:0] eTgt;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int s = 0; s < NSETS; s++) begin
      mV[0][s] = 1'b0; mV[1][s] = 1'b0; mLru[s] = 1'b0;
    end
    for (int i = 0; i < NCTR; i++) mGht[i] = 2'b01;
    mGhr = '0; mPtr = 0; mCnt = 0;
  endtask

  task automatic modelUpdate(input logic [31:0] pc, input bit tk,
                             input logic [31:0] tg, input logic [1:0] kd, input bit fl);
    int st, w;
    logic [5:0] idx;
    st  = int'(pc[5:3]);
    idx = pc[8:3] ^ mGhr;
    if (kd == 2'd0) begin
      if (tk && mGht[idx] != 2'd3) mGht[idx] = mGht[idx] + 2'd1;
      if (!tk && mGht[idx] != 2'd0) mGht[idx] = mGht[idx] - 2'd1;
      mGhr = {mGhr[4:0], tk};
    end
    if (tk) begin
      if (mV[0][st] && mTag[0][st] == pc[31:6]) w = 0;
      else if (mV[1][st] && mTag[1][st] == pc[31:6]) w = 1;
      else if (!mV[0][st]) w = 0;
      else if (!mV[1][st]) w = 1;
      else w = int'(mLru[st]);
      mV[w][st] = 1'b1; mTag[w][st] = pc[31:6];
      mTgt[w][st] = tg; mKind[w][st] = kd;
      mLru[st] = (w == 0);
    end
    if (fl) mCnt = 0;
    else if (kd == 2'd2) begin
      mRas[mPtr] = pc + 32'd8;
      mPtr = (mPtr + 1) % NRAS;
      if (mCnt < NRAS) mCnt++;
    end else if (kd == 2'd3 && mCnt > 0) begin
      mPtr = (mPtr + NRAS - 1) % NRAS;
      mCnt--;
    end
  endtask

  task automatic modelPredict(input logic [31:0] pc);
    int st, w;
    bit gt;
    logic [31:0] seq;
    st  = int'(pc[5:3]);
    gt  = mGht[pc[8:3] ^ mGhr][1];
    seq = pc + 32'd8;
    w = -1;
    if (mV[0][st] && mTag[0][st] == pc[31:6]) w = 0;
    if (mV[1][st] && mTag[1][st] == pc[31:6]) w = 1;
    eHit = (w >= 0);
    eTaken = gt; eTgt = seq;
    if (w >= 0) begin
      case (mKind[w][st])
        2'd0: begin eTaken = gt; eTgt = gt ? mTgt[w][st] : seq; end
        2'd1, 2'd2: begin eTaken = 1'b1; eTgt = mTgt[w][st]; end
        default: begin
          eTaken = (mCnt > 0);
          eTgt = (mCnt > 0) ? mRas[(mPtr + NRAS - 1) % NRAS] : seq;
        end
      endcase
    end
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    @(negedge clk);
    fetchPc = pc;
    #1;
    modelPredict(pc);
    chk(predTaken === eTaken, req, "predTaken", {31'd0, predTaken}, {31'd0, eTaken});
    chk(btbHit === eHit, req, "btbHit", {31'd0, btbHit}, {31'd0, eHit});
    chk(predTarget === eTgt, req, "predTarget", predTarget, eTgt);
    if (!predTaken) chk(predTarget === pc + 32'd8, "R2", "seqTarget", predTarget, pc + 32'd8);
  endtask

  task automatic step(input bit v, input logic [31:0] pc, input bit tk,
                      input logic [31:0] tg, input logic [1:0] kd,
                      input bit mp, input bit fl);
    @(negedge clk);
    updValid = v; updPc = pc; updTaken = tk; updTarget = tg;
    updKind = kd; updMispredict = mp; flush = fl;
    @(posedge clk);
    #1;
    updValid = 1'b0; updMispredict = 1'b0; flush = 1'b0;
    if (v) modelUpdate(pc, tk, tg, kd, fl);
    else if (fl) mCnt = 0;
    chk(flushReq === (v && mp), "R11", "flushReq", {31'd0, flushReq}, {31'd0, v && mp});
  endtask

  function automatic logic [31:0] linePc(input int tag, input int st);
    return (32'(tag) << 6) | (32'(st) << 3);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rs;
    rs = $urandom(32'd2024);
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    chk(flushReq === 1'b0, "R1", "flushReq", {31'd0, flushReq}, 32'd0);
    look(32'h0000_0100, "R1");
    look(32'h0000_2468, "R1");
    look(32'hFFFF_FFF8, "R1");

    // R6 not-taken conditional allocates nothing; R3 miss uses counters
    step(1'b1, 32'h1000, 1'b0, 32'h4000, 2'd0, 1'b0, 1'b0);
    look(32'h1000, "R6");
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 32'h0000_0200, 1'b1, 32'h0000_0800, 2'd0, 1'b0, 1'b0);
      look(32'h0000_0200, "R4");
    end
    // R5 history: conditional outcomes shift in, then aliasing lookups
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 32'h0000_0A00 + 32'(i * 8), (i % 2) == 0, 32'h0, 2'd0, 1'b0, 1'b0);
      look(32'h0000_0C00 + 32'(i * 8), "R3");
    end
    // R4 saturation at the bottom
    for (int i = 0; i < 5; i++) step(1'b1, 32'h0000_0E00, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0);
    look(32'h0000_0E00, "R4");

    // R7 eviction in set 2
    step(1'b1, linePc(5, 2), 1'b1, 32'h0000_5000, 2'd1, 1'b0, 1'b0);
    step(1'b1, linePc(6, 2), 1'b1, 32'h0000_6000, 2'd1, 1'b0, 1'b0);
    look(linePc(5, 2), "R7");
    look(linePc(6, 2), "R7");
    step(1'b1, linePc(5, 2), 1'b1, 32'h0000_5500, 2'd1, 1'b0, 1'b0);
    step(1'b1, linePc(7, 2), 1'b1, 32'h0000_7000, 2'd1, 1'b0, 1'b0);
    look(linePc(5, 2), "R7");
    look(linePc(6, 2), "R7");
    look(linePc(7, 2), "R8");

    // R8/R9 calls and returns
    step(1'b1, 32'h3000, 1'b1, 32'h9000, 2'd2, 1'b0, 1'b0);
    look(32'h3000, "R8");
    step(1'b1, 32'h9100, 1'b1, 32'h3008, 2'd3, 1'b1, 1'b0);
    look(32'h9100, "R8");
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 32'h7000 + 32'(i * 64), 1'b1, 32'h9000, 2'd2, 1'b0, 1'b0);
      look(32'h9100, "R9");
    end
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 32'h9100, 1'b1, 32'h0, 2'd3, 1'b0, 1'b0);
      look(32'h9100, "R9");
    end

    // R10 flush empties the stack, also cancelling a same-cycle push
    step(1'b1, 32'h3000, 1'b1, 32'h9000, 2'd2, 1'b0, 1'b0);
    step(1'b1, 32'h3040, 1'b1, 32'h9000, 2'd2, 1'b0, 1'b1);
    look(32'h9100, "R10");
    step(1'b1, 32'h3000, 1'b1, 32'h9000, 2'd2, 1'b0, 1'b0);
    step(1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 1'b0, 1'b1);
    look(32'h9100, "R10");

    // R11 mispredict then a clean cycle
    step(1'b1, 32'h1000, 1'b1, 32'h1800, 2'd0, 1'b1, 1'b0);
    step(1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 1'b1, 1'b0);

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] pc, tg;
      logic [1:0] kd;
      bit tk;
      int r;
      pc = linePc($urandom_range(1, 3), $urandom_range(0, 7));
      tg = $urandom() & 32'hFFFF_FFF8;
      r  = $urandom_range(0, 9);
      kd = (r < 5) ? 2'd0 : (r < 7) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
      if (r == 9 && $urandom_range(0, 1) == 1) kd = 2'd3;
      tk = (kd == 2'd0) ? ($urandom_range(0, 2) != 0) : 1'b1;
      step(1'b1, pc, tk, tg, kd, $urandom_range(0, 7) == 0, $urandom_range(0, 31) == 0);
      look(pc, "R8");
      look(linePc($urandom_range(1, 3), $urandom_range(0, 7)) | 32'($urandom_range(0, 7)), "R3");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule